// File: doc/BRIEF.md
# SRAM Regulator Transition Delay Sequencer

This block sets the timing of the power-state handshakes between an SRAM array and its low-dropout regulator. One 32-bit configuration word holds four delay fields and applies to every voltage domain the block serves. A start-up field is counted in units of 16 system clock cycles. A sleep field and a precharge field are counted in single cycles. A voltage-setup field is counted in units of 8 cycles. Each field drives its own handshake edge toward the regulator.

Four handshake inputs set the timers off. A rising `pwr_up_start` begins the start-up wait. A rising `last_bank_ret` means the last bank has gone to retention or off, and begins the sleep wait before `all_ret` is raised. A rising `ret_exit_req` while retained drops `all_ret` and begins the ramp back to active. A falling `ret_en` begins the precharge wait before `ret_good`. The retention path is a four-state machine. Its states are S_ACTIVE, S_SLEEP_WAIT, S_RETAINED and S_RAMP. Its transitions are:
- T_ENTER: S_ACTIVE to S_SLEEP_WAIT on a `last_bank_ret` rise.
- T_SETTLED: S_SLEEP_WAIT to S_RETAINED when the sleep timer expires.
- T_WAKE: S_RETAINED to S_RAMP on a `ret_exit_req` rise.
- T_RAMPED: S_RAMP to S_ACTIVE when the ramp timer expires.
- T_REENTER: S_RAMP to S_SLEEP_WAIT on a `last_bank_ret` rise.

A cold reset clears everything. A warm reset clears the timers, the state machine and the outputs, but keeps the configuration word.

Top module: `ldo_delay_sequencer`

## Requirements
- R1: After a cold reset, `cfg_rdata` reads 0x78000017 and all four handshake outputs are low.
- R2: A write with `cfg_we` high takes effect at that clock edge. From the next cycle, `cfg_rdata` shows the written word with bits 7:6 forced to zero. Bits 7:6 always read as zero.
- R3: While `warm_rst_n` is low, all four handshake outputs are low and `cfg_rdata` keeps its last written value.
- R4: Take N as bits 31:24. A rise of `pwr_up_start` is first seen at edge t. At edge t, `startup_done` clears. It rises at edge t+1+16·N.
- R5: Take N as bits 23:16. A rise of `last_bank_ret` is seen at edge t while in S_ACTIVE. Then `all_ret` rises at edge t+1+N.
- R6: Take N as bits 15:8. A rise of `ret_exit_req` is seen at edge t while `all_ret` is high. Then `all_ret` falls at edge t and `ramp_done` rises at edge t+1+8·N. Entry into S_SLEEP_WAIT clears `ramp_done`.
- R7: Take N as bits 5:0. A fall of `ret_en` is seen at edge t. Then `ret_good` rises at edge t+1+N. At any edge where `ret_en` is high, `ret_good` is cleared and the precharge count stops.
- R8: A field value of zero makes the matching output assert at the edge right after the trigger edge.
- R9: A register write during a running count does not change when that count ends.
- R10: A `last_bank_ret` rise during S_RAMP aborts the ramp. `ramp_done` stays low and the full sleep wait starts again.
- R11: A `ret_exit_req` rise outside S_RETAINED has no effect. A `last_bank_ret` rise during S_SLEEP_WAIT or S_RETAINED has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst_n | input | 1 | Active-low asynchronous cold reset (everything) |
| warm_rst_n | input | 1 | Active-low asynchronous warm reset (all but config) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| pwr_up_start | input | 1 | Regulator power-up request (rise triggers) |
| last_bank_ret | input | 1 | Last SRAM bank in retention/off (rise triggers) |
| ret_exit_req | input | 1 | Request to leave retention (rise triggers) |
| ret_en | input | 1 | Retention enable (fall triggers precharge) |
| startup_done | output | 1 | Start-up wait complete |
| all_ret | output | 1 | All banks retained, to the regulator |
| ramp_done | output | 1 | Ramp back to active complete |
| ret_good | output | 1 | Precharge wait complete |

## Verification
A wrong internal state shows at the ports as a handshake edge that comes too early, too late or not at all. Two examples are a wrong prescaler phase, which shifts `startup_done` by up to 15 cycles, and a state machine stuck outside S_RETAINED, which holds `all_ret` low. The bench runs a behavioural model and compares every output on every cycle, so such a fault is reported in the first cycle the output differs. That is usually the expected rise edge. A misread field or a count loaded at the wrong moment also shows there. A write during a count and a re-request during the ramp are run so that a count wrongly reloaded mid-flight moves an edge the bench is watching.

// File: rtl/ldo_seq_pkg.sv
package ldo_seq_pkg;

    localparam int CFG_W     = 32;

    localparam int START_LSB = 24;
    localparam int START_W   = 8;
    localparam int SLEEP_LSB = 16;
    localparam int SLEEP_W   = 8;
    localparam int VSU_LSB   = 8;
    localparam int VSU_W     = 8;
    localparam int PCH_LSB   = 0;
    localparam int PCH_W     = 6;

    localparam logic [CFG_W-1:0] CFG_RESET = 32'h7800_0017;
    localparam logic [CFG_W-1:0] CFG_MASK  = 32'hFFFF_FF3F;

    typedef enum logic [1:0] {
        S_ACTIVE     = 2'd0,
        S_SLEEP_WAIT = 2'd1,
        S_RETAINED   = 2'd2,
        S_RAMP       = 2'd3
    } ret_state_e;

endpackage

// File: rtl/ldo_cfg_reg.sv
module ldo_cfg_reg
    import ldo_seq_pkg::*;
(
    input  logic             clk,
    input  logic             cold_rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_q
);

    logic [CFG_W-1:0] word_q;

    // Only the cold reset reaches this register; the warm reset leaves it alone.
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            word_q <= CFG_RESET;
        end else if (cfg_we) begin
            word_q <= cfg_wdata & CFG_MASK;
        end
    end

    assign cfg_q = word_q;

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        cfg_we |=> (cfg_q == ($past(cfg_wdata) & CFG_MASK))); // R2

endmodule

// File: rtl/ldo_edge_det.sv
module ldo_edge_det #(
    parameter int                 N         = 4,
    parameter logic [N-1:0]       FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] edge_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= din;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (FALL_MASK[i]) begin : g_fall
            assign edge_o[i] = prev_q[i] & ~din[i];
        end else begin : g_rise
            assign edge_o[i] = ~prev_q[i] & din[i];
        end
    end

endmodule

// File: rtl/ldo_delay_timer.sv
module ldo_delay_timer #(
    parameter int CNT_W = 8,
    parameter int SCALE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    localparam int PRE_W = (SCALE > 1) ? $clog2(SCALE) : 1;

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    if (SCALE > 1) begin : g_pre
        logic [PRE_W-1:0] pre_q;

        // Prescaler restarts with each new delay so the total stays exact.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pre_q <= '0;
            end else if (start || !active_q || tick) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end

        assign tick = (pre_q == PRE_W'(SCALE - 1));
    end else begin : g_nopre
        assign tick = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (abort) begin
            active_q <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= load_val;
        end else if (active_q) begin
            if (cnt_q == '0) begin
                active_q <= 1'b0;
            end else if (tick) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign expire = active_q && (cnt_q == '0) && !start && !abort;

    AST_LOAD_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> (active_q && (cnt_q == $past(load_val)))); // R9

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !start && !abort && (cnt_q != '0)) |=> (cnt_q <= $past(cnt_q))); // R4

    AST_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !active_q); // R8

endmodule

// File: rtl/ldo_ret_fsm.sv
module ldo_ret_fsm
    import ldo_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_rise,
    input  logic exit_rise,
    input  logic sleep_expire,
    input  logic ramp_expire,
    output logic sleep_start,
    output logic ramp_start,
    output logic ramp_abort,
    output logic all_ret,
    output logic ramp_done
);

    ret_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_ENTER, T_SETTLED, T_WAKE, T_RAMPED, T_REENTER.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ACTIVE:     if (enter_rise)   state_d = S_SLEEP_WAIT;
            S_SLEEP_WAIT: if (sleep_expire) state_d = S_RETAINED;
            S_RETAINED:   if (exit_rise)    state_d = S_RAMP;
            S_RAMP: begin
                if (enter_rise)       state_d = S_SLEEP_WAIT;
                else if (ramp_expire) state_d = S_ACTIVE;
            end
        endcase
    end

    // Timer strobes and decoded outputs.
    always_comb begin
        sleep_start = 1'b0;
        ramp_start  = 1'b0;
        ramp_abort  = 1'b0;
        unique case (state_q)
            S_ACTIVE:     sleep_start = enter_rise;
            S_SLEEP_WAIT: ;
            S_RETAINED:   ramp_start  = exit_rise;
            S_RAMP: begin
                sleep_start = enter_rise;
                ramp_abort  = enter_rise;
            end
        endcase
    end

    assign all_ret = (state_q == S_RETAINED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_done <= 1'b0;
        end else if (sleep_start) begin
            ramp_done <= 1'b0;
        end else if ((state_q == S_RAMP) && ramp_expire) begin
            ramp_done <= 1'b1;
        end
    end

    AST_REENTER_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_RAMP) && enter_rise) |=> ((state_q == S_SLEEP_WAIT) && !ramp_done)); // R10

    AST_WAKE_DROPS_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (all_ret && exit_rise) |=> !all_ret); // R6

    AST_RAMP_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_done) |-> ($past(state_q) == S_RAMP)); // R6

    AST_RET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(all_ret) |-> ($past(state_q) == S_SLEEP_WAIT)); // R5

endmodule

// File: rtl/ldo_delay_sequencer.sv
module ldo_delay_sequencer
    import ldo_seq_pkg::*;
#(
    parameter int START_SCALE = 16,
    parameter int RAMP_SCALE  = 8
) (
    input  logic        clk,
    input  logic        cold_rst_n,
    input  logic        warm_rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        pwr_up_start,
    input  logic        last_bank_ret,
    input  logic        ret_exit_req,
    input  logic        ret_en,
    output logic        startup_done,
    output logic        all_ret,
    output logic        ramp_done,
    output logic        ret_good
);

    localparam int NTRIG = 4;
    localparam int E_PWR = 0;
    localparam int E_ENT = 1;
    localparam int E_EXT = 2;
    localparam int E_PCH = 3;
    localparam logic [NTRIG-1:0] FALLS = 4'b1000;

    logic             rst_n;
    logic [CFG_W-1:0] cfg_q;
    logic [NTRIG-1:0] trig;
    logic             start_exp, sleep_exp, ramp_exp, pch_exp;
    logic             sleep_start, ramp_start, ramp_abort;

    assign rst_n = cold_rst_n & warm_rst_n;

    ldo_cfg_reg u_cfg (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_q      (cfg_q)
    );

    assign cfg_rdata = cfg_q;

    ldo_edge_det #(.N(NTRIG), .FALL_MASK(FALLS)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({ret_en, ret_exit_req, last_bank_ret, pwr_up_start}),
        .edge_o (trig)
    );

    ldo_delay_timer #(.CNT_W(START_W), .SCALE(START_SCALE)) u_start_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (trig[E_PWR]),
        .abort    (1'b0),
        .load_val (cfg_q[START_LSB +: START_W]),
        .expire   (start_exp)
    );

    ldo_delay_timer #(.CNT_W(SLEEP_W), .SCALE(1)) u_sleep_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sleep_start),
        .abort    (1'b0),
        .load_val (cfg_q[SLEEP_LSB +: SLEEP_W]),
        .expire   (sleep_exp)
    );

    ldo_delay_timer #(.CNT_W(VSU_W), .SCALE(RAMP_SCALE)) u_ramp_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ramp_start),
        .abort    (ramp_abort),
        .load_val (cfg_q[VSU_LSB +: VSU_W]),
        .expire   (ramp_exp)
    );

    ldo_delay_timer #(.CNT_W(PCH_W), .SCALE(1)) u_pch_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (trig[E_PCH]),
        .abort    (ret_en),
        .load_val (cfg_q[PCH_LSB +: PCH_W]),
        .expire   (pch_exp)
    );

    ldo_ret_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_rise   (trig[E_ENT]),
        .exit_rise    (trig[E_EXT]),
        .sleep_expire (sleep_exp),
        .ramp_expire  (ramp_exp),
        .sleep_start  (sleep_start),
        .ramp_start   (ramp_start),
        .ramp_abort   (ramp_abort),
        .all_ret      (all_ret),
        .ramp_done    (ramp_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            startup_done <= 1'b0;
        end else if (trig[E_PWR]) begin
            startup_done <= 1'b0;
        end else if (start_exp) begin
            startup_done <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_good <= 1'b0;
        end else if (trig[E_PCH] || ret_en) begin
            ret_good <= 1'b0;
        end else if (pch_exp) begin
            ret_good <= 1'b1;
        end
    end

    AST_STARTUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trig[E_PWR] |=> !startup_done); // R4

    AST_GOOD_NEEDS_LOW_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> !ret_good); // R7

endmodule

// File: tb/sim_ldo_delay_sequencer.sv
module sim_ldo_delay_sequencer;

    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 150000;
    localparam logic [31:0] RST_WORD = 32'h7800_0017;
    localparam logic [31:0] WR_MASK  = 32'hFFFF_FF3F;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pwr_up_start = 1'b0;
    logic        last_bank_ret = 1'b0;
    logic        ret_exit_req = 1'b0;
    logic        ret_en = 1'b0;
    logic        startup_done, all_ret, ramp_done, ret_good;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldo_delay_sequencer u0 (
        .clk           (clk),
        .cold_rst_n    (cold_rst_n),
        .warm_rst_n    (warm_rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .pwr_up_start  (pwr_up_start),
        .last_bank_ret (last_bank_ret),
        .ret_exit_req  (ret_exit_req),
        .ret_en        (ret_en),
        .startup_done  (startup_done),
        .all_ret       (all_ret),
        .ramp_done     (ramp_done),
        .ret_good      (ret_good)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cfg;
    bit  m_pp, m_pl, m_px, m_pe;
    int  m_mode;          // 0 active, 1 sleep wait, 2 retained, 3 ramping
    int  m_st, m_sl, m_rp, m_pc;
    bit  m_sdone, m_rdone, m_good;

    task automatic m_clear();
        m_pp = 0; m_pl = 0; m_px = 0; m_pe = 0;
        m_mode = 0; m_st = -1; m_sl = -1; m_rp = -1; m_pc = -1;
        m_sdone = 0; m_rdone = 0; m_good = 0;
    endtask

    always @(posedge clk or negedge cold_rst_n or negedge warm_rst_n) begin
        if (!cold_rst_n) begin
            m_cfg = RST_WORD;
            m_clear();
        end else if (!warm_rst_n) begin
            m_clear();
        end else begin
            bit rp, rl, rx, fe;
            rp = pwr_up_start && !m_pp;
            rl = last_bank_ret && !m_pl;
            rx = ret_exit_req && !m_px;
            fe = !ret_en && m_pe;
            // start-up
            if (rp) begin
                m_sdone = 0; m_st = 16 * int'(m_cfg[31:24]);
            end else if (m_st == 0) begin
                m_sdone = 1; m_st = -1;
            end else if (m_st > 0) m_st--;
            // retention path
            case (m_mode)
                0: if (rl) begin m_mode = 1; m_sl = int'(m_cfg[23:16]); m_rdone = 0; end
                1: if (m_sl == 0) m_mode = 2; else m_sl--;
                2: if (rx) begin m_mode = 3; m_rp = 8 * int'(m_cfg[15:8]); end
                default: begin
                    if (rl) begin m_mode = 1; m_sl = int'(m_cfg[23:16]); m_rdone = 0; end
                    else if (m_rp == 0) begin m_mode = 0; m_rdone = 1; end
                    else m_rp--;
                end
            endcase
            // precharge
            if (fe) begin
                m_good = 0; m_pc = int'(m_cfg[5:0]);
            end else if (ret_en) begin
                m_good = 0; m_pc = -1;
            end else if (m_pc == 0) begin
                m_good = 1; m_pc = -1;
            end else if (m_pc > 0) m_pc--;
            if (cfg_we) m_cfg = cfg_wdata & WR_MASK;
            m_pp = pwr_up_start; m_pl = last_bank_ret; m_px = ret_exit_req; m_pe = ret_en;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        check(cfg_rdata == m_cfg,         "R2", cfg_rdata, m_cfg);
        check(startup_done == m_sdone,    "R4", 32'(startup_done), 32'(m_sdone));
        check(all_ret == (m_mode == 2),   "R5", 32'(all_ret), 32'(m_mode == 2));
        check(ramp_done == m_rdone,       "R6", 32'(ramp_done), 32'(m_rdone));
        check(ret_good == m_good,         "R7", 32'(ret_good), 32'(m_good));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        cold_rst_n = 1'b1; warm_rst_n = 1'b1;
        tick(1);
        check(cfg_rdata == RST_WORD, "R1", cfg_rdata, RST_WORD);
        check({startup_done, all_ret, ramp_done, ret_good} == 4'b0, "R1",
              32'({startup_done, all_ret, ramp_done, ret_good}), 0);

        // R4: start-up with default field 0x78 -> 1+16*120 edges after trigger edge
        pwr_up_start = 1'b1;
        tick(1 + 16 * 120);
        check(startup_done == 1'b0, "R4", 32'(startup_done), 0);
        tick(1);
        check(startup_done == 1'b1, "R4", 32'(startup_done), 1);
        pwr_up_start = 1'b0;

        // R2: reserved bits 7:6 dropped; fields start 10, sleep 5, setup 3, precharge 4
        wr(32'h0A05_03C4);
        check(cfg_rdata == 32'h0A05_0304, "R2", cfg_rdata, 32'h0A05_0304);

        // R11: exit request while active does nothing
        ret_exit_req = 1'b1;
        tick(3);
        check({all_ret, ramp_done} == 2'b00, "R11", 32'({all_ret, ramp_done}), 0);
        ret_exit_req = 1'b0;
        tick(1);

        // R5: sleep wait of 5
        last_bank_ret = 1'b1;
        tick(6);
        check(all_ret == 1'b0, "R5", 32'(all_ret), 0);
        tick(1);
        check(all_ret == 1'b1, "R5", 32'(all_ret), 1);

        // R6: ramp of 8*3
        ret_exit_req = 1'b1;
        tick(1);
        check(all_ret == 1'b0, "R6", 32'(all_ret), 0);
        tick(24);
        check(ramp_done == 1'b0, "R6", 32'(ramp_done), 0);
        tick(1);
        check(ramp_done == 1'b1, "R6", 32'(ramp_done), 1);
        ret_exit_req = 1'b0; last_bank_ret = 1'b0;
        tick(2);

        // R11: second rise during sleep wait does not restart it
        last_bank_ret = 1'b1;
        tick(3);
        last_bank_ret = 1'b0;
        tick(1);
        last_bank_ret = 1'b1;
        tick(2);
        check(all_ret == 1'b0, "R11", 32'(all_ret), 0);
        tick(1);
        check(all_ret == 1'b1, "R11", 32'(all_ret), 1);

        // R10: re-request during ramp aborts it and restarts sleep
        ret_exit_req = 1'b1;
        tick(5);
        last_bank_ret = 1'b0;
        tick(1);
        last_bank_ret = 1'b1;
        tick(1);
        check({all_ret, ramp_done} == 2'b00, "R10", 32'({all_ret, ramp_done}), 0);
        tick(5);
        check(all_ret == 1'b0, "R10", 32'(all_ret), 0);
        tick(1);
        check(all_ret == 1'b1, "R10", 32'(all_ret), 1);
        check(ramp_done == 1'b0, "R10", 32'(ramp_done), 0);
        ret_exit_req = 1'b0;
        tick(1);

        // R9: setup field rewritten to 0x40 mid-ramp; ramp still ends 1+24 edges on
        ret_exit_req = 1'b1;
        tick(1);
        wr(32'h0A05_4004);
        tick(23);
        check(ramp_done == 1'b0, "R9", 32'(ramp_done), 0);
        tick(1);
        check(ramp_done == 1'b1, "R9", 32'(ramp_done), 1);
        ret_exit_req = 1'b0;

        // R7: precharge of 4 after ret_en falls
        ret_en = 1'b1;
        tick(3);
        check(ret_good == 1'b0, "R7", 32'(ret_good), 0);
        ret_en = 1'b0;
        tick(5);
        check(ret_good == 1'b0, "R7", 32'(ret_good), 0);
        tick(1);
        check(ret_good == 1'b1, "R7", 32'(ret_good), 1);
        ret_en = 1'b1;
        tick(1);
        check(ret_good == 1'b0, "R7", 32'(ret_good), 0);

        // R8: all fields zero
        wr(32'h0000_0000);
        last_bank_ret = 1'b0;
        tick(1);
        last_bank_ret = 1'b1; pwr_up_start = 1'b1; ret_en = 1'b0;
        tick(1);
        check({all_ret, startup_done, ret_good} == 3'b000, "R8",
              32'({all_ret, startup_done, ret_good}), 0);
        tick(1);
        check({all_ret, startup_done, ret_good} == 3'b111, "R8",
              32'({all_ret, startup_done, ret_good}), 32'h7);

        // R3: warm reset keeps configuration, clears outputs
        wr(32'h1234_5637);
        pwr_up_start = 1'b0; last_bank_ret = 1'b0;
        warm_rst_n = 1'b0;
        tick(2);
        check(cfg_rdata == 32'h1234_5637, "R3", cfg_rdata, 32'h1234_5637);
        check({startup_done, all_ret, ramp_done, ret_good} == 4'b0, "R3",
              32'({startup_done, all_ret, ramp_done, ret_good}), 0);
        warm_rst_n = 1'b1;
        tick(2);

        // R1: cold reset restores the default word
        cold_rst_n = 1'b0;
        tick(2);
        cold_rst_n = 1'b1;
        tick(1);
        check(cfg_rdata == RST_WORD, "R1", cfg_rdata, RST_WORD);

        finish_run();
    end

endmodule